// File: doc/BRIEF.md
# Scale-Space Peak Detector

This block decides whether one candidate sample of a multi-scale blob response is a feature point. Each accepted input carries a 3x3x3 cube of signed response values: a 3x3 window from the candidate's own scale plus the matching windows from the scales directly below and above. The candidate sits in the middle of that cube. A point is reported only when its value is larger than a threshold that can be rewritten at run time, and strictly larger than every one of its 26 neighbours.

Each input also carries the column, row and scale index of the candidate. The block passes them through so that each result names where the point is. Results are suppressed for candidates whose cube cannot be complete: points on the outermost ring of the image, and points on the lowest or highest of the scales. The block is a two-stage pipeline. It takes one cube per clock and gives a result exactly two clocks after each accepted cube.

A two-state machine tracks whether the first stage holds a cube. In ST_IDLE the first stage is empty. In ST_BUSY it holds a cube whose comparison results move to the outputs on the next edge. The transition IDLE_TO_BUSY and the transition BUSY_TO_BUSY are both taken on a clock with `in_valid` high. BUSY_TO_IDLE and IDLE_TO_IDLE are taken on a clock with `in_valid` low. Reset forces ST_IDLE.

Top module: `nms_3d_peak`

## Requirements
- R1: While reset is asserted, and after it is released until the first result arrives, `out_valid` and `out_feat` are 0. The threshold resets to 0.
- R2: A cube accepted with `in_valid` high at clock edge k gives `out_valid` high after edge k+2, carrying that cube's `in_x`, `in_y` and `in_scale`. A clock with `in_valid` low gives `out_valid` low two edges later. One cube per clock is accepted with no gaps needed.
- R3: A point is reported only if its center value is strictly greater than the threshold, compared as signed values. A center equal to the threshold is suppressed.
- R4: The cube is packed as 27 words of VAL_W bits. Word index = slice*9 + row*3 + col, where slice 0 is the lower scale, slice 1 the own scale and slice 2 the upper scale. Word 13 is the center. A point is reported only if the center is strictly greater than each of the other 26 words, so a tie with any same-scale neighbour suppresses it.
- R5: Neighbours in the lower slice (words 0 to 8) and the upper slice (words 18 to 26) suppress a point exactly as same-scale neighbours do.
- R6: A threshold write (`thr_we` high with `thr_wdata`) applies to the first cube accepted on a later clock edge. A cube accepted on the same edge as the write is judged against the previous threshold.
- R7: A point with `in_x` equal to 0 or IMG_W-1, or `in_y` equal to 0 or IMG_H-1, is never reported.
- R8: A point with `in_scale` equal to 0 or NUM_SCALES-1 is never reported. Only the interior scales 1 to NUM_SCALES-2 can give features.
- R9: `out_feat` is never high while `out_valid` is low.
- R10: All comparisons are signed. Negative thresholds, centers and neighbours are ordered as two's-complement numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | VAL_W (32) | New threshold value, signed |
| in_valid | input | 1 | Cube on `in_cube` is accepted this clock |
| in_cube | input | 27*VAL_W (864) | Packed response cube, word 13 is the center |
| in_x | input | X_W (10) | Candidate column |
| in_y | input | Y_W (9) | Candidate row |
| in_scale | input | S_W (3) | Candidate scale index |
| out_valid | output | 1 | A result is present |
| out_feat | output | 1 | The result is a feature point |
| out_x | output | X_W (10) | Column of the result |
| out_y | output | Y_W (9) | Row of the result |
| out_scale | output | S_W (3) | Scale of the result |

## Verification
The hardest case to reach is a threshold write on the same edge as an accepted cube. Here the old threshold must still decide, and the very next cube must see the new one. The stimulus sets both strobes in one cycle with a center that lies between the old and new thresholds. It then repeats that center on the next cycle. Ties are driven one neighbour position at a time across all 26 positions, so a missed comparator in either outer slice shows up as a reported feature.

// File: rtl/nms_pkg.sv
package nms_pkg;
    localparam int CUBE_CELLS  = 27;
    localparam int CUBE_CENTER = 13;
    localparam int CUBE_NBRS   = CUBE_CELLS - 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } nms_state_e;
endpackage

// File: rtl/nms_thresh_reg.sv
module nms_thresh_reg #(
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VAL_W-1:0] wdata,
    output logic [VAL_W-1:0] thr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (we) begin
            thr_q <= wdata;
        end
    end
endmodule

// File: rtl/nms_cube_cmp.sv
module nms_cube_cmp
    import nms_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic [CUBE_CELLS*VAL_W-1:0] cube,
    input  logic [VAL_W-1:0]            thr,
    output logic [CUBE_NBRS-1:0]        nbr_gt,
    output logic                        thr_gt
);
    logic signed [VAL_W-1:0] center;

    assign center = $signed(cube[CUBE_CENTER*VAL_W +: VAL_W]);
    assign thr_gt = center > $signed(thr);

    for (genvar i = 0; i < CUBE_CELLS; i++) begin : g_cell
        if (i < CUBE_CENTER) begin : g_below
            assign nbr_gt[i] = center > $signed(cube[i*VAL_W +: VAL_W]);
        end else if (i > CUBE_CENTER) begin : g_above
            assign nbr_gt[i-1] = center > $signed(cube[i*VAL_W +: VAL_W]);
        end
    end
endmodule

// File: rtl/nms_pos_gate.sv
module nms_pos_gate #(
    parameter int IMG_W      = 640,
    parameter int IMG_H      = 480,
    parameter int NUM_SCALES = 8,
    parameter int X_W        = 10,
    parameter int Y_W        = 9,
    parameter int S_W        = 3
) (
    input  logic [X_W-1:0] x,
    input  logic [Y_W-1:0] y,
    input  logic [S_W-1:0] scale,
    output logic           interior
);
    localparam logic [X_W-1:0] X_LAST = X_W'(IMG_W - 1);
    localparam logic [Y_W-1:0] Y_LAST = Y_W'(IMG_H - 1);
    localparam logic [S_W-1:0] S_LAST = S_W'(NUM_SCALES - 1);

    logic x_ok, y_ok, s_ok;

    always_comb begin
        x_ok     = (x != '0) && (x < X_LAST);
        y_ok     = (y != '0) && (y < Y_LAST);
        s_ok     = (scale != '0) && (scale < S_LAST);
        interior = x_ok && y_ok && s_ok;
    end
endmodule

// File: rtl/nms_3d_peak.sv
module nms_3d_peak
    import nms_pkg::*;
#(
    parameter int VAL_W      = 32,
    parameter int IMG_W      = 640,
    parameter int IMG_H      = 480,
    parameter int NUM_SCALES = 8,
    parameter int X_W        = $clog2(IMG_W),
    parameter int Y_W        = $clog2(IMG_H),
    parameter int S_W        = $clog2(NUM_SCALES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        thr_we,
    input  logic [VAL_W-1:0]            thr_wdata,
    input  logic                        in_valid,
    input  logic [CUBE_CELLS*VAL_W-1:0] in_cube,
    input  logic [X_W-1:0]              in_x,
    input  logic [Y_W-1:0]              in_y,
    input  logic [S_W-1:0]              in_scale,
    output logic                        out_valid,
    output logic                        out_feat,
    output logic [X_W-1:0]              out_x,
    output logic [Y_W-1:0]              out_y,
    output logic [S_W-1:0]              out_scale
);
    nms_state_e state_q, state_d;

    logic [VAL_W-1:0]     thr_q;
    logic [CUBE_NBRS-1:0] nbr_gt;
    logic                 thr_gt;
    logic                 interior;

    logic [CUBE_NBRS-1:0] s1_nbr_gt;
    logic                 s1_thr_gt;
    logic                 s1_interior;
    logic [X_W-1:0]       s1_x;
    logic [Y_W-1:0]       s1_y;
    logic [S_W-1:0]       s1_scale;

    nms_thresh_reg #(.VAL_W(VAL_W)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (thr_we),
        .wdata (thr_wdata),
        .thr_q (thr_q)
    );

    nms_cube_cmp #(.VAL_W(VAL_W)) u_cmp (
        .cube   (in_cube),
        .thr    (thr_q),
        .nbr_gt (nbr_gt),
        .thr_gt (thr_gt)
    );

    nms_pos_gate #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .NUM_SCALES(NUM_SCALES),
        .X_W(X_W), .Y_W(Y_W), .S_W(S_W)
    ) u_pos (
        .x        (in_x),
        .y        (in_y),
        .scale    (in_scale),
        .interior (interior)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_BUSY : ST_IDLE;
            ST_BUSY: state_d = in_valid ? ST_BUSY : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // First stage: comparison results of the accepted cube
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_nbr_gt   <= '0;
            s1_thr_gt   <= 1'b0;
            s1_interior <= 1'b0;
            s1_x        <= '0;
            s1_y        <= '0;
            s1_scale    <= '0;
        end else if (in_valid) begin
            s1_nbr_gt   <= nbr_gt;
            s1_thr_gt   <= thr_gt;
            s1_interior <= interior;
            s1_x        <= in_x;
            s1_y        <= in_y;
            s1_scale    <= in_scale;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_feat  <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_scale <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    out_valid <= 1'b0;
                    out_feat  <= 1'b0;
                end
                ST_BUSY: begin
                    out_valid <= 1'b1;
                    out_feat  <= (&s1_nbr_gt) && s1_thr_gt && s1_interior;
                    out_x     <= s1_x;
                    out_y     <= s1_y;
                    out_scale <= s1_scale;
                end
                default: begin
                    out_valid <= 1'b0;
                    out_feat  <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/nms_3d_check.sv
module nms_3d_check
    import nms_pkg::*;
#(
    parameter int VAL_W      = 32,
    parameter int IMG_W      = 640,
    parameter int IMG_H      = 480,
    parameter int NUM_SCALES = 8,
    parameter int X_W        = 10,
    parameter int Y_W        = 9,
    parameter int S_W        = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [CUBE_CELLS*VAL_W-1:0] in_cube,
    input logic [X_W-1:0]              in_x,
    input logic [Y_W-1:0]              in_y,
    input logic [S_W-1:0]              in_scale,
    input logic [VAL_W-1:0]            thr_q,
    input logic                        out_valid,
    input logic                        out_feat,
    input logic [X_W-1:0]              out_x,
    input logic [Y_W-1:0]              out_y,
    input logic [S_W-1:0]              out_scale
);
    logic signed [VAL_W-1:0] ctr;
    assign ctr = $signed(in_cube[CUBE_CENTER*VAL_W +: VAL_W]);

    AST_FEAT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_feat |-> out_valid); // R9

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2

    AST_GAP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R2

    AST_POS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)
                          && out_scale == $past(in_scale, 2))); // R2

    AST_THR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(ctr > $signed(thr_q))) |=> ##1 !out_feat); // R3

    AST_NO_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_feat |-> (out_x != '0 && out_x != X_W'(IMG_W - 1)
                      && out_y != '0 && out_y != Y_W'(IMG_H - 1))); // R7

    AST_INNER_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        out_feat |-> (out_scale != '0 && out_scale != S_W'(NUM_SCALES - 1))); // R8
endmodule

bind nms_3d_peak nms_3d_check #(
    .VAL_W(VAL_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .NUM_SCALES(NUM_SCALES),
    .X_W(X_W), .Y_W(Y_W), .S_W(S_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_cube   (in_cube),
    .in_x      (in_x),
    .in_y      (in_y),
    .in_scale  (in_scale),
    .thr_q     (thr_q),
    .out_valid (out_valid),
    .out_feat  (out_feat),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_scale (out_scale)
);

// File: tb/nms_3d_peak_test.sv
module nms_3d_peak_test;
    localparam int VW = 32;
    localparam int W  = 640;
    localparam int H  = 480;
    localparam int NS = 8;
    localparam int XW = 10;
    localparam int YW = 9;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thr_we = 1'b0;
    logic [VW-1:0] thr_wdata = '0;
    logic in_valid = 1'b0;
    logic [27*VW-1:0] in_cube = '0;
    logic [XW-1:0] in_x = '0;
    logic [YW-1:0] in_y = '0;
    logic [SW-1:0] in_scale = '0;
    logic out_valid, out_feat;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;
    logic [SW-1:0] out_scale;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    nms_3d_peak uut (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .in_valid(in_valid), .in_cube(in_cube), .in_x(in_x), .in_y(in_y),
        .in_scale(in_scale), .out_valid(out_valid), .out_feat(out_feat),
        .out_x(out_x), .out_y(out_y), .out_scale(out_scale)
    );

    // Reference model: two-deep queue of expected results
    int m_thr = 0;
    bit p1v, p1f, p2v, p2f;
    int p1x, p1y, p1s, p2x, p2y, p2s;
    string p1t = "R1", p2t = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_thr = 0; p1v = 0; p1f = 0; p2v = 0; p2f = 0;
        end else begin
            int c;
            bit ok;
            p2v = p1v; p2f = p1f; p2x = p1x; p2y = p1y; p2s = p1s; p2t = p1t;
            c  = $signed(in_cube[13*VW +: VW]);
            ok = in_valid && (c > m_thr);
            for (int i = 0; i < 27; i++)
                if (i != 13 && !(c > $signed(in_cube[i*VW +: VW]))) ok = 0;
            if (in_x == 0 || in_x == W-1 || in_y == 0 || in_y == H-1) ok = 0;
            if (in_scale == 0 || in_scale == NS-1) ok = 0;
            p1v = in_valid; p1f = ok;
            p1x = in_x; p1y = in_y; p1s = in_scale; p1t = cur_tag;
            if (thr_we) m_thr = $signed(thr_wdata);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (out_valid !== p2v || out_feat !== p2f ||
                (p2v && (out_x != p1x - p1x + p2x || out_y != p2y || out_scale != p2s))) begin
                n_bad++;
                $display("FAIL %s: actual v=%0b f=%0b x=%0d y=%0d s=%0d expected v=%0b f=%0b x=%0d y=%0d s=%0d",
                         p2t, out_valid, out_feat, out_x, out_y, out_scale,
                         p2v, p2f, p2x, p2y, p2s);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2: watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic put(input int c, input int n, input int k, input int kv,
                       input int x, input int y, input int s, input string t);
        @(negedge clk);
        for (int i = 0; i < 27; i++) in_cube[i*VW +: VW] = n;
        if (k >= 0) in_cube[k*VW +: VW] = kv;
        in_cube[13*VW +: VW] = c;
        in_valid = 1; in_x = XW'(x); in_y = YW'(y); in_scale = SW'(s);
        thr_we = 0; cur_tag = t;
    endtask

    task automatic gap(input int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            in_valid = 0; thr_we = 0; cur_tag = "R9";
        end
    endtask

    task automatic set_thr(input int v);
        @(negedge clk);
        in_valid = 0; thr_we = 1; thr_wdata = v; cur_tag = "R9";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || out_feat !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual v=%0b f=%0b expected v=0 f=0", out_valid, out_feat);
        end
        rst_n = 1;
        gap(3);
        // R2: back-to-back stream, then alternating gaps
        for (int i = 0; i < 6; i++) put(50, 10, -1, 0, 10 + i, 20 + i, 1 + i, "R2");
        gap(2);
        for (int i = 0; i < 4; i++) begin
            put(40 + i, 45, -1, 0, 300 + i, 200 + i, 2 + i, "R2");
            gap(1);
        end
        // R3: strict threshold
        set_thr(100);
        put(100, 50, -1, 0, 5, 5, 3, "R3");
        put(101, 50, -1, 0, 6, 5, 3, "R3");
        put(99, 50, -1, 0, 7, 5, 3, "R3");
        gap(2);
        // R4 / R5: one tie per neighbour position, then one just below
        for (int k = 0; k < 27; k++) begin
            if (k != 13) begin
                put(200, 150, k, 200, 30 + k, 40, 2, (k < 9 || k > 17) ? "R5" : "R4");
                put(200, 150, k, 201, 30 + k, 41, 2, (k < 9 || k > 17) ? "R5" : "R4");
                put(200, 150, k, 199, 30 + k, 42, 2, "R4");
            end
        end
        gap(2);
        // R6: write on same edge as an accepted cube
        put(300, 10, -1, 0, 60, 60, 4, "R6");
        thr_we = 1; thr_wdata = 500;
        put(300, 10, -1, 0, 61, 60, 4, "R6");
        put(501, 10, -1, 0, 62, 60, 4, "R6");
        put(500, 10, -1, 0, 63, 60, 4, "R6");
        gap(2);
        // R7: border positions
        set_thr(0);
        put(900, 1, -1, 0, 0, 100, 3, "R7");
        put(900, 1, -1, 0, W - 1, 100, 3, "R7");
        put(900, 1, -1, 0, 100, 0, 3, "R7");
        put(900, 1, -1, 0, 100, H - 1, 3, "R7");
        put(900, 1, -1, 0, 1, 1, 3, "R7");
        put(900, 1, -1, 0, W - 2, H - 2, 3, "R7");
        // R8: outer scales
        put(900, 1, -1, 0, 50, 50, 0, "R8");
        put(900, 1, -1, 0, 50, 50, NS - 1, "R8");
        put(900, 1, -1, 0, 50, 50, 1, "R8");
        put(900, 1, -1, 0, 50, 50, NS - 2, "R8");
        gap(2);
        // R10: signed ordering
        set_thr(-1000);
        put(-5, -10, -1, 0, 70, 70, 2, "R10");
        put(-1000, -2000, -1, 0, 71, 70, 2, "R10");
        put(-5, 3, -1, 0, 72, 70, 2, "R10");
        put(-5, -10, 20, -4, 73, 70, 2, "R10");
        put(-999, -2000, -1, 0, 74, 70, 2, "R10");
        gap(4);
        finish_run();
    end
endmodule